// File: doc/BRIEF.md
# Thermal Sensor Register File

This block holds the programmable registers of an on-board thermal sensor and decodes the byte traffic that reaches them from a serial bus front end. The front end presents three things: a start strobe with the address byte, the bytes of a write, and read requests. The block checks the address byte against a fixed device type code and the board-strapped subaddress pins. In a write transfer, the first byte loads a pointer and each following pair of bytes is a 16-bit register write, most significant byte first. In a read transfer, each request returns the next byte of the register the pointer selects, starting with the most significant byte.

Six 16-bit registers sit behind the pointer: capability, configuration, upper alarm limit, lower alarm limit, critical limit and temperature. The capability and temperature registers cannot be written. The configuration register carries two lock bits. The alarm lock protects the two window limits. The critical lock protects the critical limit. Either lock freezes the event-mode and polarity bits. The limits and the configuration are presented on dedicated outputs for the comparison logic. A clear request written to the configuration register leaves the block as a one-cycle pulse.

Top module: `thermal_regfile`

## Requirements
- R1: After reset the configuration, upper, lower and critical registers read 0x0000, the capability register reads 0x0001, and the pointer selects the capability register (value 0).
- R2: A start strobe selects the block only when address bits 7:4 equal 0011 and bits 3:1 equal `sub_pins`. Bit 0 is 1 for a read transfer and 0 for a write transfer. `addr_ack` pulses in the cycle after a matching start. Bytes and read requests in a transfer that is not selected change nothing and return no data.
- R3: In a write transfer the first byte loads the pointer from its bits 2:0, but only if bits 7:3 are zero; otherwise the pointer keeps its value. Each following byte pair writes the pointed register with the MSB byte first. The register changes on the edge that accepts the LSB byte, and further pairs repeat the write.
- R4: In a read transfer each request yields `rd_valid` and one byte on `rd_data` in the following cycle. The bytes alternate MSB, LSB, starting with MSB at every new start.
- R5: The capability register (pointer 0) is read-only and always reads 0x0001.
- R6: The temperature register (pointer 5) is read-only. It reads {crit_flag, above_flag, below_flag, temp_sample[12:0]} as registered one cycle earlier.
- R7: While configuration bit 6 (alarm lock) is set, writes to the upper (pointer 2) and lower (pointer 3) limits are ignored.
- R8: While configuration bit 7 (critical lock) is set, writes to the critical limit (pointer 4) are ignored.
- R9: While either lock bit is set, configuration bits 1:0 keep their value on a write. Bits 3:2 and 10:8 remain writable.
- R10: Configuration bit 4 reads the `evt_status` input and bits 15:11 read zero. Bit 5 reads zero, and writing it as 1 raises `clr_evt` for exactly one cycle, starting after the LSB edge.
- R11: A lock bit, once set, stays set through any write and is cleared only by reset.
- R12: Pointer values 6 and 7 read 0x0000, and writes through them change no register.
- R13: `cfg_out`, `upper_out`, `lower_out` and `crit_out` show the stored register contents. `cfg_out` has bits 4, 5 and 15:11 at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_pins | input | 3 | Strapped subaddress bits |
| start | input | 1 | Start of transfer, address byte valid |
| addr_byte | input | 8 | Address byte: type code, subaddress, read flag |
| stop | input | 1 | End of transfer, deselects the block |
| byte_valid | input | 1 | Write byte present |
| byte_in | input | 8 | Write byte |
| rd_req | input | 1 | Request for the next read byte |
| evt_status | input | 1 | Event status from the comparison logic |
| crit_flag | input | 1 | Temperature above critical |
| above_flag | input | 1 | Temperature above the window |
| below_flag | input | 1 | Temperature below the window |
| temp_sample | input | 13 | Current temperature sample |
| addr_ack | output | 1 | Address matched, one-cycle pulse |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| cfg_out | output | 16 | Stored configuration |
| upper_out | output | 16 | Upper alarm limit |
| lower_out | output | 16 | Lower alarm limit |
| crit_out | output | 16 | Critical limit |
| clr_evt | output | 1 | Clear-event pulse |

## Verification
Locks are one-way, so once a random write sets one, the rest of the run can no longer reach the unlocked threshold and mode-bit paths. The stimulus therefore runs in two parts. The first part is random with the lock bits masked off and checks every write against a bench model. The second part sets each lock with directed writes, proves that reset is the only way out, and then runs unmasked random traffic against the locked model. Pointer bytes with nonzero upper bits, pointers 6 and 7, and transfers to a foreign subaddress are mixed into the random traffic.

// File: rtl/thermal_regfile_pkg.sv
package thermal_regfile_pkg;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int PTR_W    = 3;
  localparam int FLAG_W   = 3;
  localparam int SAMPLE_W = WORD_W - FLAG_W;

  localparam logic [PTR_W-1:0] SEL_CAP   = 3'd0;
  localparam logic [PTR_W-1:0] SEL_CFG   = 3'd1;
  localparam logic [PTR_W-1:0] SEL_UPPER = 3'd2;
  localparam logic [PTR_W-1:0] SEL_LOWER = 3'd3;
  localparam logic [PTR_W-1:0] SEL_CRIT  = 3'd4;
  localparam logic [PTR_W-1:0] SEL_TEMP  = 3'd5;

  localparam int CFG_MODE   = 0;
  localparam int CFG_POL    = 1;
  localparam int CFG_STATUS = 4;
  localparam int CFG_CLR    = 5;
  localparam int CFG_ALOCK  = 6;
  localparam int CFG_CLOCK  = 7;

  localparam logic [WORD_W-1:0] CFG_FREE_MASK = 16'h070C;
  localparam logic [WORD_W-1:0] CAP_MASK      = 16'h001F;

  typedef enum logic [1:0] {
    PH_PTR = 2'd0,
    PH_HI  = 2'd1,
    PH_LO  = 2'd2
  } wr_phase_e;
endpackage

// File: rtl/thermal_addr_match.sv
module thermal_addr_match #(
  parameter int TYPE_W = 4,
  parameter int SUB_W  = 3,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b0011,
  localparam int ADDR_W = TYPE_W + SUB_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SUB_W-1:0]  sub_pins_i,
  input  logic              stop_i,
  output logic              sel_o,
  output logic              rd_mode_o,
  output logic              ack_o
);
  logic hit;

  assign hit = (addr_i[ADDR_W-1 -: TYPE_W] == TYPE_CODE) &&
               (addr_i[SUB_W:1] == sub_pins_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o     <= 1'b0;
      rd_mode_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      ack_o <= start_i && hit;
      if (start_i) begin
        sel_o     <= hit;
        rd_mode_o <= addr_i[0];
      end else if (stop_i) begin
        sel_o <= 1'b0;
      end
    end
  end

  // R2: acknowledge only follows a start
  a_r2_ack_after_start: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(start_i));
  // R2: selection only arises from a start
  a_r2_sel_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_o) |-> $past(start_i));
endmodule

// File: rtl/thermal_byte_seq.sv
module thermal_byte_seq
  import thermal_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              rd_mode_i,
  input  logic              start_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_req_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  wr_phase_e         phase_q;
  logic [BYTE_W-1:0] hi_q;
  logic              rd_msb_q;
  logic              wr_take;
  logic              rd_take;

  assign wr_take   = sel_i && !rd_mode_i && byte_valid_i && !start_i;
  assign rd_take   = sel_i &&  rd_mode_i && rd_req_i && !start_i;
  assign wr_en_o   = wr_take && (phase_q == PH_LO);
  assign wr_data_o = {hi_q, byte_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_PTR;
      hi_q    <= '0;
      ptr_o   <= SEL_CAP;
    end else if (start_i) begin
      phase_q <= PH_PTR;
    end else if (wr_take) begin
      unique case (phase_q)
        PH_PTR: begin
          if (byte_i[BYTE_W-1:PTR_W] == '0) ptr_o <= byte_i[PTR_W-1:0];
          phase_q <= PH_HI;
        end
        PH_HI: begin
          hi_q    <= byte_i;
          phase_q <= PH_LO;
        end
        default: phase_q <= PH_HI;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_msb_q   <= 1'b1;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_take;
      if (start_i) begin
        rd_msb_q <= 1'b1;
      end else if (rd_take) begin
        rd_data_o <= rd_msb_q ? rd_word_i[WORD_W-1:BYTE_W] : rd_word_i[BYTE_W-1:0];
        rd_msb_q  <= !rd_msb_q;
      end
    end
  end

  // R4: a read byte only follows a request
  a_r4_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_req_i) && $past(sel_i));
  // R3: a register write never happens while a read transfer is selected
  a_r3_no_write_in_read: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> !rd_mode_i);
  // R3: a write needs an earlier byte on this transfer
  a_r3_write_after_hi: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(byte_valid_i));
endmodule

// File: rtl/thermal_reg_bank.sv
module thermal_reg_bank
  import thermal_regfile_pkg::*;
#(
  parameter logic [WORD_W-1:0] CAP_VALUE = 16'h0001
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PTR_W-1:0]    ptr_i,
  input  logic                wr_en_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic                evt_status_i,
  input  logic                crit_flag_i,
  input  logic                above_flag_i,
  input  logic                below_flag_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [WORD_W-1:0]   rd_word_o,
  output logic [WORD_W-1:0]   cfg_o,
  output logic [WORD_W-1:0]   upper_o,
  output logic [WORD_W-1:0]   lower_o,
  output logic [WORD_W-1:0]   crit_o,
  output logic                clr_evt_o
);
  localparam int THR_N = 3;

  logic [WORD_W-1:0] cfg_q;
  logic [WORD_W-1:0] cfg_next;
  logic [WORD_W-1:0] temp_q;
  logic [WORD_W-1:0] thr_q [THR_N];
  logic              clr_q;
  logic              alm_lock;
  logic              crit_lock;
  logic              cfg_wr;

  assign alm_lock  = cfg_q[CFG_ALOCK];
  assign crit_lock = cfg_q[CFG_CLOCK];
  assign cfg_wr    = wr_en_i && (ptr_i == SEL_CFG);

  always_comb begin
    cfg_next = (cfg_q & ~CFG_FREE_MASK) | (wr_data_i & CFG_FREE_MASK);
    if (!(alm_lock || crit_lock)) begin
      cfg_next[CFG_MODE] = wr_data_i[CFG_MODE];
      cfg_next[CFG_POL]  = wr_data_i[CFG_POL];
    end
    cfg_next[CFG_ALOCK] = alm_lock  | wr_data_i[CFG_ALOCK];
    cfg_next[CFG_CLOCK] = crit_lock | wr_data_i[CFG_CLOCK];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= cfg_wr && wr_data_i[CFG_CLR];
      if (cfg_wr) cfg_q <= cfg_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) temp_q <= '0;
    else     temp_q <= {crit_flag_i, above_flag_i, below_flag_i, sample_i};
  end

  for (genvar g = 0; g < THR_N; g++) begin : g_thr
    localparam logic [PTR_W-1:0] MY_PTR = SEL_UPPER + PTR_W'(g);
    logic lock_g;
    assign lock_g = (g == THR_N - 1) ? crit_lock : alm_lock;

    always_ff @(posedge clk) begin
      if (rst) thr_q[g] <= '0;
      else if (wr_en_i && (ptr_i == MY_PTR) && !lock_g) thr_q[g] <= wr_data_i;
    end

    // R7 (alarm limits) and R8 (critical limit): locked limits hold
    a_r7_thr_locked: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && (ptr_i == MY_PTR) && lock_g) |=> $stable(thr_q[g]));
  end

  always_comb begin
    unique case (ptr_i)
      SEL_CAP:   rd_word_o = CAP_VALUE & CAP_MASK;
      SEL_CFG:   rd_word_o = cfg_q | (WORD_W'(evt_status_i) << CFG_STATUS);
      SEL_UPPER: rd_word_o = thr_q[0];
      SEL_LOWER: rd_word_o = thr_q[1];
      SEL_CRIT:  rd_word_o = thr_q[2];
      SEL_TEMP:  rd_word_o = temp_q;
      default:   rd_word_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign upper_o   = thr_q[0];
  assign lower_o   = thr_q[1];
  assign crit_o    = thr_q[2];
  assign clr_evt_o = clr_q;

  // R11: locks are sticky
  a_r11_alarm_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    alm_lock |=> alm_lock);
  a_r11_crit_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    crit_lock |=> crit_lock);
  // R9: mode and polarity frozen under either lock
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (alm_lock || crit_lock) |=> $stable(cfg_q[CFG_POL:CFG_MODE]));
  // R13: status, clear and reserved bits never stored
  a_r13_cfg_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_q[WORD_W-1:11] == '0 && !cfg_q[CFG_STATUS] && !cfg_q[CFG_CLR]);
endmodule

// File: rtl/thermal_regfile.sv
module thermal_regfile
  import thermal_regfile_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int SUB_W  = 3,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b0011,
  parameter logic [WORD_W-1:0] CAP_VALUE = 16'h0001
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SUB_W-1:0]    sub_pins,
  input  logic                start,
  input  logic [BYTE_W-1:0]   addr_byte,
  input  logic                stop,
  input  logic                byte_valid,
  input  logic [BYTE_W-1:0]   byte_in,
  input  logic                rd_req,
  input  logic                evt_status,
  input  logic                crit_flag,
  input  logic                above_flag,
  input  logic                below_flag,
  input  logic [SAMPLE_W-1:0] temp_sample,
  output logic                addr_ack,
  output logic                rd_valid,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [WORD_W-1:0]   cfg_out,
  output logic [WORD_W-1:0]   upper_out,
  output logic [WORD_W-1:0]   lower_out,
  output logic [WORD_W-1:0]   crit_out,
  output logic                clr_evt
);
  logic              sel;
  logic              rd_mode;
  logic [PTR_W-1:0]  ptr;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_word;

  thermal_addr_match #(
    .TYPE_W(TYPE_W), .SUB_W(SUB_W), .TYPE_CODE(TYPE_CODE)
  ) u_match (
    .clk(clk), .rst(rst), .start_i(start), .addr_i(addr_byte),
    .sub_pins_i(sub_pins), .stop_i(stop),
    .sel_o(sel), .rd_mode_o(rd_mode), .ack_o(addr_ack)
  );

  thermal_byte_seq u_seq (
    .clk(clk), .rst(rst), .sel_i(sel), .rd_mode_i(rd_mode), .start_i(start),
    .byte_valid_i(byte_valid), .byte_i(byte_in), .rd_req_i(rd_req),
    .rd_word_i(rd_word), .ptr_o(ptr), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  thermal_reg_bank #(.CAP_VALUE(CAP_VALUE)) u_bank (
    .clk(clk), .rst(rst), .ptr_i(ptr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .evt_status_i(evt_status), .crit_flag_i(crit_flag), .above_flag_i(above_flag),
    .below_flag_i(below_flag), .sample_i(temp_sample), .rd_word_o(rd_word),
    .cfg_o(cfg_out), .upper_o(upper_out), .lower_o(lower_out), .crit_o(crit_out),
    .clr_evt_o(clr_evt)
  );

  // R10: the clear request lasts a single cycle
  a_r10_clr_single: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> !clr_evt);
  // R10: the clear request only follows a register write
  a_r10_clr_after_write: assert property (@(posedge clk) disable iff (rst)
    clr_evt |-> $past(wr_en));
endmodule

// File: tb/thermal_regfile_tb.sv
module thermal_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] SUB = 3'b101;
  localparam logic [7:0] WADDR = {4'b0011, SUB, 1'b0};
  localparam logic [7:0] RADDR = {4'b0011, SUB, 1'b1};
  localparam logic [7:0] BADW  = {4'b0011, 3'b100, 1'b0};
  localparam logic [7:0] BADR  = {4'b0111, SUB, 1'b1};

  logic clk = 0, rst = 1;
  logic start = 0, stop = 0, byte_valid = 0, rd_req = 0;
  logic [7:0] addr_byte = 0, byte_in = 0;
  logic evt_status = 0, crit_flag = 0, above_flag = 0, below_flag = 0;
  logic [12:0] temp_sample = 0;
  logic addr_ack, rd_valid, clr_evt;
  logic [7:0] rd_data;
  logic [15:0] cfg_out, upper_out, lower_out, crit_out;

  int checks = 0, errors = 0, clr_cnt = 0;
  bit done = 0;

  logic [15:0] m_cfg, m_thr [3];
  logic [2:0]  m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (!rst && clr_evt) clr_cnt++;

  thermal_regfile u_dut (
    .clk(clk), .rst(rst), .sub_pins(SUB), .start(start), .addr_byte(addr_byte),
    .stop(stop), .byte_valid(byte_valid), .byte_in(byte_in), .rd_req(rd_req),
    .evt_status(evt_status), .crit_flag(crit_flag), .above_flag(above_flag),
    .below_flag(below_flag), .temp_sample(temp_sample), .addr_ack(addr_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .cfg_out(cfg_out), .upper_out(upper_out),
    .lower_out(lower_out), .crit_out(crit_out), .clr_evt(clr_evt)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic void model_reset();
    m_cfg = 0; m_thr[0] = 0; m_thr[1] = 0; m_thr[2] = 0; m_ptr = 0;
  endfunction

  function automatic void model_write(input logic [15:0] d);
    logic lk;
    lk = m_cfg[6] | m_cfg[7];
    case (m_ptr)
      3'd1: begin
        m_cfg[3:2]  = d[3:2];
        m_cfg[10:8] = d[10:8];
        if (!lk) m_cfg[1:0] = d[1:0];
        m_cfg[7:6] = m_cfg[7:6] | d[7:6];
      end
      3'd2: if (!m_cfg[6]) m_thr[0] = d;
      3'd3: if (!m_cfg[6]) m_thr[1] = d;
      3'd4: if (!m_cfg[7]) m_thr[2] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] model_read(input logic [2:0] p);
    case (p)
      3'd0: return 16'h0001;
      3'd1: return m_cfg | {11'd0, evt_status, 4'd0};
      3'd2: return m_thr[0];
      3'd3: return m_thr[1];
      3'd4: return m_thr[2];
      3'd5: return {crit_flag, above_flag, below_flag, temp_sample};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic do_start(input logic [7:0] a);
    @(negedge clk); start = 1; addr_byte = a;
    @(negedge clk); start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); byte_valid = 0; rd_req = 0; stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_valid = 1; byte_in = b;
    @(negedge clk); byte_valid = 0;
  endtask

  // write frame: pointer byte then npairs copies of data
  task automatic wr_frame(input logic [7:0] a, input logic [7:0] p,
                          input logic [15:0] d, input int npairs);
    do_start(a);
    send_byte(p);
    for (int k = 0; k < npairs; k++) begin
      send_byte(d[15:8]);
      send_byte(d[7:0]);
    end
    do_stop();
    if (a == WADDR) begin
      if (p[7:3] == 0) m_ptr = p[2:0];
      for (int k = 0; k < npairs; k++) model_write(d);
    end
  endtask

  task automatic rd_frame(input logic [7:0] a, output logic [15:0] w, output int nvalid);
    nvalid = 0; w = 0;
    do_start(a);
    rd_req = 1; @(negedge clk); rd_req = 0;
    if (rd_valid) nvalid++;
    w[15:8] = rd_data;
    rd_req = 1; @(negedge clk); rd_req = 0;
    if (rd_valid) nvalid++;
    w[7:0] = rd_data;
    do_stop();
  endtask

  task automatic read_check(input string req, input logic [2:0] p);
    logic [15:0] w; int nv;
    wr_frame(WADDR, {5'd0, p}, 16'h0, 0);
    rd_frame(RADDR, w, nv);
    check(req, w, model_read(p));
    check({req, " valid count"}, 16'(nv), 16'd2);
  endtask

  task automatic check_outputs(input string req);
    check({req, " cfg_out"}, cfg_out, m_cfg);
    check({req, " upper_out"}, upper_out, m_thr[0]);
    check({req, " lower_out"}, lower_out, m_thr[1]);
    check({req, " crit_out"}, crit_out, m_thr[2]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    model_reset();
  endtask

  initial begin
    logic [15:0] w; int nv; int c0;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    check_outputs("R1");
    rd_frame(RADDR, w, nv);
    check("R1 pointer selects capability", w, 16'h0001);
    for (int p = 1; p < 5; p++) read_check("R1", 3'(p));

    // R2 address match and ack
    @(negedge clk); start = 1; addr_byte = WADDR;
    @(negedge clk); start = 0;
    check("R2 ack after match", 16'(addr_ack), 16'd1);
    do_stop();
    @(negedge clk); start = 1; addr_byte = BADW;
    @(negedge clk); start = 0;
    check("R2 no ack on foreign subaddress", 16'(addr_ack), 16'd0);
    do_stop();
    wr_frame(BADW, 8'h02, 16'hBEEF, 1);
    read_check("R2 foreign write ignored", 3'd2);
    rd_frame(BADR, w, nv);
    check("R2 foreign read gives no data", 16'(nv), 16'd0);

    // R3 write framing, multi pair, bad pointer byte
    wr_frame(WADDR, 8'h02, 16'h1234, 1);
    read_check("R3 upper write", 3'd2);
    wr_frame(WADDR, 8'h03, 16'h0A5F, 2);
    read_check("R3 two pairs", 3'd3);
    wr_frame(WADDR, 8'h4C, 16'h7777, 1);
    read_check("R3 bad pointer keeps 3", 3'd3);
    check("R3 upper untouched", upper_out, 16'h1234);

    // R4 byte order restarts at MSB on every start
    wr_frame(WADDR, 8'h04, 16'hC3A1, 1);
    do_start(RADDR);
    rd_req = 1; @(negedge clk); rd_req = 0;
    check("R4 first byte MSB", 16'(rd_data), 16'h00C3);
    check("R4 valid", 16'(rd_valid), 16'd1);
    @(negedge clk);
    check("R4 valid drops", 16'(rd_valid), 16'd0);
    do_start(RADDR);
    rd_req = 1; @(negedge clk); rd_req = 0;
    check("R4 restart MSB", 16'(rd_data), 16'h00C3);
    do_stop();

    // R5 capability read-only
    wr_frame(WADDR, 8'h00, 16'hFFFF, 1);
    read_check("R5", 3'd0);

    // R6 temperature read-only
    crit_flag = 1; above_flag = 0; below_flag = 1; temp_sample = 13'h1ABC;
    wr_frame(WADDR, 8'h05, 16'h0000, 1);
    read_check("R6", 3'd5);

    // R10 status bit, reserved bits, clear pulse
    evt_status = 1;
    c0 = clr_cnt;
    wr_frame(WADDR, 8'h01, 16'hF83C, 1);
    read_check("R10 cfg readback", 3'd1);
    check("R10 single clear pulse", 16'(clr_cnt - c0), 16'd1);
    evt_status = 0;
    read_check("R10 status follows input", 3'd1);

    // R12 pointers 6 and 7
    wr_frame(WADDR, 8'h06, 16'h5555, 1);
    read_check("R12 ptr6", 3'd6);
    wr_frame(WADDR, 8'h07, 16'hAAAA, 1);
    read_check("R12 ptr7", 3'd7);
    check_outputs("R12 no change");

    // random phase without locks
    for (int i = 0; i < 120; i++) begin
      logic [2:0] p; logic [15:0] d; int kind;
      p = 3'($urandom_range(0, 7));
      d = 16'($urandom);
      if (p == 3'd1) d = d & ~16'h00C0;
      kind = $urandom_range(0, 9);
      evt_status = 1'($urandom);
      crit_flag = 1'($urandom); above_flag = 1'($urandom); below_flag = 1'($urandom);
      temp_sample = 13'($urandom);
      c0 = clr_cnt;
      if (kind == 0) wr_frame(BADW, {5'd0, p}, d, 1);
      else wr_frame(WADDR, {5'd0, p}, d, 1 + (kind & 1));
      if (kind != 0 && p == 3'd1)
        check("R10 random clear count", 16'(clr_cnt - c0), 16'(d[5] ? 1 + (kind & 1) : 0));
      read_check("R3 random", p);
      check_outputs("R13 random");
    end

    // R9 mode bits freeze once a lock is set
    wr_frame(WADDR, 8'h01, 16'h0003, 1);
    wr_frame(WADDR, 8'h01, 16'h0043, 1);
    wr_frame(WADDR, 8'h01, 16'h0008, 1);
    read_check("R9 mode frozen, bit3 free", 3'd1);
    check("R9 mode bits", cfg_out & 16'h0003, 16'h0003);

    // R7 alarm lock
    wr_frame(WADDR, 8'h02, 16'h0F0F, 1);
    read_check("R7 upper locked", 3'd2);
    wr_frame(WADDR, 8'h03, 16'hF0F0, 1);
    read_check("R7 lower locked", 3'd3);
    wr_frame(WADDR, 8'h04, 16'h1111, 1);
    read_check("R8 crit still free", 3'd4);
    check("R8 crit free value", crit_out, 16'h1111);

    // R11 lock cannot be cleared by write
    wr_frame(WADDR, 8'h01, 16'h0000, 1);
    check("R11 alarm lock sticky", 16'(cfg_out[6]), 16'd1);

    // R8 critical lock
    wr_frame(WADDR, 8'h01, 16'h0080, 1);
    wr_frame(WADDR, 8'h04, 16'h2222, 1);
    read_check("R8 crit locked", 3'd4);
    check("R8 crit value held", crit_out, 16'h1111);

    // R11 reset clears locks
    do_reset();
    check("R11 reset clears locks", cfg_out, 16'h0000);
    wr_frame(WADDR, 8'h02, 16'h4321, 1);
    read_check("R11 upper writable after reset", 3'd2);

    // random phase with locks allowed
    for (int i = 0; i < 120; i++) begin
      logic [2:0] p; logic [7:0] pb; logic [15:0] d;
      p = 3'($urandom_range(0, 7));
      pb = ($urandom_range(0, 7) == 0) ? 8'($urandom) : {5'd0, p};
      d = 16'($urandom);
      if (p == 3'd1 && $urandom_range(0, 3) != 0) d = d & ~16'h00C0;
      evt_status = 1'($urandom);
      temp_sample = 13'($urandom);
      wr_frame(WADDR, pb, d, 1);
      rd_frame(RADDR, w, nv);
      check("R7 R8 R9 random locked", w, model_read(m_ptr));
      check_outputs("R13 random locked");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule